// File: doc/BRIEF.md
# DDR2 Command Decoder and Power-State Tracker

This block watches the command pins that a memory controller drives toward a DDR2 device and, at every rising clock edge, classifies what was sampled. It combines the clock-enable level of the previous edge with the current clock-enable, chip select, row strobe, column strobe, write enable, bank select and address bits. The result is a one-hot command vector, a bank field and an auto-precharge bit. All three are registered and valid for exactly one cycle.

A small state machine follows the device's power state. The states are `ST_ACTIVE`, `ST_PDOWN` (power-down) and `ST_SREF` (self-refresh). The transitions are:
- `ST_ACTIVE -> ST_PDOWN` on power-down entry.
- `ST_ACTIVE -> ST_SREF` on self-refresh entry.
- `ST_PDOWN -> ST_ACTIVE` and `ST_SREF -> ST_ACTIVE` on a valid exit.
- Every state holds on any other code.
- Reset or reinitialize forces `ST_ACTIVE` from any state.

Any encoding that is undefined in the current state sets a sticky `illegal` flag. The same flag is set by any of the following:
- a read or write that cuts into a running BL=4 burst;
- a nonzero reserved bit when mode register 3 is written;
- a power-down that lasts longer than the programmable refresh limit.

Only `reinit` (or `rst`) clears the flag. It is meant as a protocol monitor placed beside the controller or the PHY.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: After `rst` or a `reinit` pulse, the block is in a known reset state. `pwr_state` is 0 (`ST_ACTIVE`), and `illegal`, `pd_starved`, `cmd_oh`, `cmd_bank` and `cmd_ap` are all 0.
- R2: All outputs are registered. A command sampled at one rising edge appears on the outputs right after that edge and lasts one cycle. The decode applies when clock-enable is high at both the previous and current edge and chip select is low. {ras_n,cas_n,we_n} maps to `cmd_oh` bits as follows:
  - 000: bit 2, mode register set.
  - 001: bit 3, refresh.
  - 011: bit 6, activate.
  - 100: bit 7, write.
  - 101: bit 8, read.
  - 111: bit 0, no-op.
- R3: Precharge is encoded {ras_n,cas_n,we_n} = 010.
  - With addr[10] = 0 it is single-bank precharge (bit 4) and reports `ba` on `cmd_bank`.
  - With addr[10] = 1 it is precharge-all (bit 5) and reports `cmd_bank` = 0.
  - For reads and writes, `cmd_ap` equals addr[10] and `cmd_bank` equals `ba`.
  - For all other commands, `cmd_ap` is 0. `cmd_bank` is also 0, except for mode register set, activate and precharge.
- R4: With clock-enable high at both edges and chip select high, the command is deselect (bit 1), whatever the strobes are.
- R5: Self-refresh entry is clock-enable going high to low with chip select low and strobes 001. It gives bit 9 and `pwr_state` = 2.
- R6: Power-down entry gives bit 10 and `pwr_state` = 1. It is clock-enable going high to low while the bus carries no-op or deselect. Exit from either low-power state gives bit 11 and `pwr_state` = 0. It is clock-enable going low to high while the bus carries no-op or deselect.
- R7: In power-down or self-refresh, edges with clock-enable low at both edges produce no command and no error, whatever the bus carries. Any other encoding in these states is illegal, and the state does not change.
- R8: The parameter BURST_LEN sets the burst (default 4). A read or write that arrives fewer than BURST_LEN/2 cycles after the previous accepted read or write is illegal. With the default, the next read or write two cycles later is accepted.
- R9: The block counts the edges spent in power-down with clock-enable held low. If the count exceeds `pd_limit`, `pd_starved` and `illegal` are set. With `pd_limit` = 3, the fourth such edge sets both. `pd_starved` clears when power-down is left. Self-refresh is not counted.
- R10: A mode register set with `ba` = 3 (mode register 3) must have every address bit at zero. Any nonzero bit, including addr[10], makes it illegal.
- R11: An illegal event produces no command bit. Undefined encodings such as strobes 110 with clock-enable high at both edges are illegal. `illegal` stays 1 until `reinit` or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Synchronous reinitialize pulse; clears the sticky flag and state |
| cke | input | 1 | Clock-enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W (2) | Bank / mode-register select |
| addr | input | ADDR_W (14) | Address bus; bit AP_BIT (10) is the precharge/auto-precharge qualifier |
| pd_limit | input | PD_CNT_W (16) | Largest allowed count of power-down edges |
| cmd_oh | output | NCMD (12) | One-hot decoded command, one cycle |
| cmd_bank | output | BANK_W (2) | Bank of the decoded command |
| cmd_ap | output | 1 | Auto-precharge on decoded read/write |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| illegal | output | 1 | Sticky protocol-violation flag |
| pd_starved | output | 1 | Power-down has exceeded the refresh limit |

## Verification
Several properties are checked by assertions on every cycle:
- `cmd_oh` never has more than one bit set.
- `illegal` never drops without a reinitialize.
- No command other than an exit leaves a low-power state.
- Accepted reads and writes are never back to back.
- `pd_starved` always implies `illegal`.
- Exit and self-refresh entry pulses agree with the reported power state.

Other behaviours can only be shown by the bench scenarios, which replay concrete bus sequences. These cover the exact command codes, bank and auto-precharge values, and the two-cycle burst spacing. They also cover the fourth-edge refresh-limit trip, the mode-register-3 reserved-bit check, and the clearing action of `reinit`.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

    // Decoded command kinds; values 0..NCMD-1 are the one-hot bit positions.
    typedef enum logic [3:0] {
        C_NOP   = 4'd0,
        C_DESEL = 4'd1,
        C_MRS   = 4'd2,
        C_REF   = 4'd3,
        C_PRE   = 4'd4,
        C_PREA  = 4'd5,
        C_ACT   = 4'd6,
        C_WR    = 4'd7,
        C_RD    = 4'd8,
        C_SRE   = 4'd9,
        C_PDE   = 4'd10,
        C_EXIT  = 4'd11,
        C_HOLD  = 4'd12,
        C_BAD   = 4'd13
    } cmd_e;

    localparam int NCMD = 12;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_PDOWN  = 2'd1,
        ST_SREF   = 2'd2
    } pstate_e;

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_trk_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int BANK_W   = 2,
    parameter int EMR3_IDX = 3,
    parameter int AP_BIT   = 10
) (
    input  logic              cke_prev,
    input  logic              cke_now,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              code
);

    logic [2:0] strobes;
    logic       bus_idle;
    logic       emr3_dirty;

    assign strobes    = {ras_n, cas_n, we_n};
    assign bus_idle   = cs_n || (strobes == 3'b111);
    assign emr3_dirty = (ba == BANK_W'(EMR3_IDX)) && (|addr);

    always_comb begin
        code = C_BAD;
        unique case ({cke_prev, cke_now})
            2'b11: begin
                if (cs_n) begin
                    code = C_DESEL;
                end else begin
                    unique case (strobes)
                        3'b000:  code = emr3_dirty ? C_BAD : C_MRS;
                        3'b001:  code = C_REF;
                        3'b010:  code = addr[AP_BIT] ? C_PREA : C_PRE;
                        3'b011:  code = C_ACT;
                        3'b100:  code = C_WR;
                        3'b101:  code = C_RD;
                        3'b111:  code = C_NOP;
                        default: code = C_BAD;
                    endcase
                end
            end
            2'b10: begin
                if (!cs_n && strobes == 3'b001) code = C_SRE;
                else if (bus_idle)              code = C_PDE;
                else                            code = C_BAD;
            end
            2'b01:   code = bus_idle ? C_EXIT : C_BAD;
            default: code = C_HOLD;
        endcase
    end

endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic busy
);

    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int CW        = $clog2(BURST_CYC + 1);

    logic [CW-1:0] left;

    assign busy = (left != '0);

    always_ff @(posedge clk) begin
        if (rst || clr)  left <= '0;
        else if (start)  left <= CW'(BURST_CYC - 1);
        else if (busy)   left <= left - 1'b1;
    end

    // R8: remaining burst cycles never exceed the burst span
    a_r8_left_range: assert property (@(posedge clk) disable iff (rst)
        left <= CW'(BURST_CYC - 1));

endmodule

// File: rtl/ddr2_pd_timer.sv
module ddr2_pd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             over
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = (&cnt) ? cnt : cnt + 1'b1;
    assign over    = run && (cnt_nxt > limit);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (run)    cnt <= cnt_nxt;
    end

    // R9: the counter only moves while power-down is being held
    a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
    import ddr2_trk_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int BANK_W    = 2,
    parameter int AP_BIT    = 10,
    parameter int EMR3_IDX  = 3,
    parameter int BURST_LEN = 4,
    parameter int PD_CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reinit,
    input  logic                cke,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic [BANK_W-1:0]   ba,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PD_CNT_W-1:0] pd_limit,
    output logic [NCMD-1:0]     cmd_oh,
    output logic [BANK_W-1:0]   cmd_bank,
    output logic                cmd_ap,
    output logic [1:0]          pwr_state,
    output logic                illegal,
    output logic                pd_starved
);

    pstate_e state, next_state;
    logic    cke_q;
    cmd_e    code;
    logic    emit, bad, busy, pd_over, rdwr_go, has_bank;
    logic    wipe;

    assign wipe = rst || reinit;

    ddr2_cmd_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .EMR3_IDX(EMR3_IDX), .AP_BIT(AP_BIT)
    ) u_dec (
        .cke_prev(cke_q), .cke_now(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .code(code)
    );

    ddr2_burst_guard #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .rst(rst), .clr(reinit), .start(rdwr_go), .busy(busy)
    );

    ddr2_pd_timer #(.CNT_W(PD_CNT_W)) u_pdt (
        .clk(clk), .rst(rst), .clr(reinit || state != ST_PDOWN),
        .run(state == ST_PDOWN && code == C_HOLD),
        .limit(pd_limit), .over(pd_over)
    );

    // Next-state and legality
    always_comb begin
        next_state = state;
        emit       = 1'b0;
        bad        = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                unique case (code)
                    C_NOP, C_DESEL, C_MRS, C_REF, C_PRE, C_PREA, C_ACT: emit = 1'b1;
                    C_WR, C_RD: begin
                        emit = !busy;
                        bad  = busy;
                    end
                    C_SRE: begin
                        emit       = 1'b1;
                        next_state = ST_SREF;
                    end
                    C_PDE: begin
                        emit       = 1'b1;
                        next_state = ST_PDOWN;
                    end
                    default: bad = 1'b1;
                endcase
            end
            ST_PDOWN, ST_SREF: begin
                unique case (code)
                    C_HOLD: ;
                    C_EXIT: begin
                        emit       = 1'b1;
                        next_state = ST_ACTIVE;
                    end
                    default: bad = 1'b1;
                endcase
            end
            default: bad = 1'b1;
        endcase
    end

    assign rdwr_go  = emit && (code == C_WR || code == C_RD);
    assign has_bank = (code == C_MRS || code == C_PRE || code == C_ACT ||
                       code == C_WR  || code == C_RD);

    // State register (plus clock-enable history)
    always_ff @(posedge clk) begin
        if (wipe) begin
            state <= ST_ACTIVE;
            cke_q <= 1'b1;
        end else begin
            state <= next_state;
            cke_q <= cke;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (wipe) begin
            cmd_oh     <= '0;
            cmd_bank   <= '0;
            cmd_ap     <= 1'b0;
            illegal    <= 1'b0;
            pd_starved <= 1'b0;
        end else begin
            cmd_oh     <= emit ? (NCMD'(1) << code) : '0;
            cmd_bank   <= (emit && has_bank) ? ba : '0;
            cmd_ap     <= rdwr_go ? addr[AP_BIT] : 1'b0;
            illegal    <= illegal || bad || pd_over;
            pd_starved <= (next_state == ST_PDOWN) && (pd_starved || pd_over);
        end
    end

    assign pwr_state = state;

    // R2: at most one command bit per cycle
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_oh));

    // R11: the violation flag only drops through reinitialize
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (illegal && !reinit) |=> illegal);

    // R7: from a low-power state only an exit may be reported
    a_r7_lp_quiet: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != 2'd0 && !reinit) |=>
            ((cmd_oh & ~(NCMD'(1) << C_EXIT)) == '0));

    // R8: accepted reads/writes are never on consecutive cycles
    a_r8_spacing: assert property (@(posedge clk) disable iff (rst)
        ((cmd_oh[C_RD] || cmd_oh[C_WR]) && !reinit) |=>
            !(cmd_oh[C_RD] || cmd_oh[C_WR]));

    // R9: a starved power-down is always reported as a violation
    a_r9_starve_flag: assert property (@(posedge clk) disable iff (rst)
        pd_starved |-> illegal);

    // R6: an exit pulse coincides with the active state
    a_r6_exit_state: assert property (@(posedge clk) disable iff (rst)
        cmd_oh[C_EXIT] |-> (pwr_state == 2'd0));

    // R5: a self-refresh entry pulse coincides with the self-refresh state
    a_r5_sre_state: assert property (@(posedge clk) disable iff (rst)
        cmd_oh[C_SRE] |-> (pwr_state == 2'd2));

endmodule

// File: tb/sim_ddr2_cmd_tracker.sv
module sim_ddr2_cmd_tracker;

    localparam int NC = 12;
    localparam int X_NOP = 0, X_DES = 1, X_MRS = 2, X_REF = 3, X_PRE = 4,
                   X_PREA = 5, X_ACT = 6, X_WR = 7, X_RD = 8, X_SRE = 9,
                   X_PDE = 10, X_EXIT = 11, NONE = -1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reinit = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [13:0] addr = '0;
    logic [15:0] pd_limit = 16'd3;
    logic [NC-1:0] cmd_oh;
    logic [1:0]  cmd_bank;
    logic        cmd_ap;
    logic [1:0]  pwr_state;
    logic        illegal, pd_starved;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ddr2_cmd_tracker u0 (
        .clk(clk), .rst(rst), .reinit(reinit), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .pd_limit(pd_limit), .cmd_oh(cmd_oh), .cmd_bank(cmd_bank),
        .cmd_ap(cmd_ap), .pwr_state(pwr_state), .illegal(illegal),
        .pd_starved(pd_starved)
    );

    typedef struct packed {
        logic [NC-1:0] oh;
        logic [1:0]    bank;
        logic          ap;
        logic [1:0]    st;
        logic          ill;
        logic          stv;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    function automatic exp_t obs();
        exp_t o;
        o.oh = cmd_oh; o.bank = cmd_bank; o.ap = cmd_ap;
        o.st = pwr_state; o.ill = illegal; o.stv = pd_starved;
        return o;
    endfunction

    // Driver: apply one bus sample and push what must appear after that edge
    task automatic step(input string tag, input logic rin, input logic k,
                        input logic cs, input logic [2:0] rcw,
                        input logic [1:0] b, input logic [13:0] a,
                        input int ix, input logic [1:0] eb, input logic eap,
                        input logic [1:0] est, input logic eill, input logic estv);
        exp_t e;
        @(negedge clk);
        reinit = rin; cke = k; cs_n = cs;
        {ras_n, cas_n, we_n} = rcw;
        ba = b; addr = a;
        e.oh   = (ix >= 0) ? (NC'(1) << ix) : '0;
        e.bank = eb; e.ap = eap; e.st = est; e.ill = eill; e.stv = estv;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic do_reinit();
        step("R1 reinit clears", 1'b1, 1'b1, 1'b1, 3'b111, 2'd0, 14'h0,
             NONE, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    endtask

    // Monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t e, o;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                o = obs();
                total++;
                if (o !== e) begin
                    bad++;
                    $display("FAIL %s: got oh=%h bank=%0d ap=%0b st=%0d ill=%0b stv=%0b exp oh=%h bank=%0d ap=%0b st=%0d ill=%0b stv=%0b",
                             t, o.oh, o.bank, o.ap, o.st, o.ill, o.stv,
                             e.oh, e.bank, e.ap, e.st, e.ill, e.stv);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, sampled before the next edge
        total++;
        if (cmd_oh !== '0 || pwr_state !== 2'd0 || illegal !== 1'b0 ||
            pd_starved !== 1'b0 || cmd_ap !== 1'b0 || cmd_bank !== 2'd0) begin
            bad++;
            $display("FAIL R1 reset: got oh=%h st=%0d ill=%0b exp oh=0 st=0 ill=0",
                     cmd_oh, pwr_state, illegal);
        end

        // Normal traffic
        step("R2 nop",        0, 1, 0, 3'b111, 2'd0, 14'h0,    X_NOP,  0, 0, 0, 0, 0);
        step("R4 deselect",   0, 1, 1, 3'b000, 2'd2, 14'h0,    X_DES,  0, 0, 0, 0, 0);
        step("R2 activate",   0, 1, 0, 3'b011, 2'd2, 14'h0,    X_ACT,  2, 0, 0, 0, 0);
        step("R2 write",      0, 1, 0, 3'b100, 2'd2, 14'h0,    X_WR,   2, 0, 0, 0, 0);
        step("R8 gap nop",    0, 1, 0, 3'b111, 2'd0, 14'h0,    X_NOP,  0, 0, 0, 0, 0);
        step("R8 R3 read ap", 0, 1, 0, 3'b101, 2'd1, 14'h0400, X_RD,   1, 1, 0, 0, 0);
        step("R2 nop",        0, 1, 0, 3'b111, 2'd0, 14'h0,    X_NOP,  0, 0, 0, 0, 0);
        step("R3 pre one",    0, 1, 0, 3'b010, 2'd3, 14'h0,    X_PRE,  3, 0, 0, 0, 0);
        step("R3 pre all",    0, 1, 0, 3'b010, 2'd1, 14'h0400, X_PREA, 0, 0, 0, 0, 0);
        step("R2 refresh",    0, 1, 0, 3'b001, 2'd0, 14'h0,    X_REF,  0, 0, 0, 0, 0);
        step("R10 mrs emr1",  0, 1, 0, 3'b000, 2'd1, 14'h0044, X_MRS,  1, 0, 0, 0, 0);
        step("R10 emr3 zero", 0, 1, 0, 3'b000, 2'd3, 14'h0,    X_MRS,  3, 0, 0, 0, 0);
        step("R6 pd entry",   0, 0, 1, 3'b000, 2'd0, 14'h0,    X_PDE,  0, 0, 1, 0, 0);
        step("R7 hold bus",   0, 0, 0, 3'b011, 2'd1, 14'h0,    NONE,   0, 0, 1, 0, 0);
        step("R7 hold",       0, 0, 1, 3'b111, 2'd0, 14'h0,    NONE,   0, 0, 1, 0, 0);
        step("R6 pd exit",    0, 1, 0, 3'b111, 2'd0, 14'h0,    X_EXIT, 0, 0, 0, 0, 0);
        step("R5 sr entry",   0, 0, 0, 3'b001, 2'd0, 14'h0,    X_SRE,  0, 0, 2, 0, 0);
        for (int i = 0; i < 5; i++)
            step("R9 sr not counted", 0, 0, 1, 3'b111, 2'd0, 14'h0, NONE, 0, 0, 2, 0, 0);
        step("R6 sr exit",    0, 1, 1, 3'b111, 2'd0, 14'h0,    X_EXIT, 0, 0, 0, 0, 0);
        step("R2 nop",        0, 1, 0, 3'b111, 2'd0, 14'h0,    X_NOP,  0, 0, 0, 0, 0);

        // Burst cut short
        step("R8 write",      0, 1, 0, 3'b100, 2'd0, 14'h0,    X_WR,   0, 0, 0, 0, 0);
        step("R8 read cuts",  0, 1, 0, 3'b101, 2'd0, 14'h0,    NONE,   0, 0, 0, 1, 0);
        step("R11 sticky",    0, 1, 0, 3'b111, 2'd0, 14'h0,    X_NOP,  0, 0, 0, 1, 0);
        do_reinit();

        // Mode register 3 reserved bit
        step("R10 emr3 a10",  0, 1, 0, 3'b000, 2'd3, 14'h0400, NONE,   0, 0, 0, 1, 0);
        do_reinit();

        // Undefined encoding
        step("R11 undefined", 0, 1, 0, 3'b110, 2'd0, 14'h0,    NONE,   0, 0, 0, 1, 0);
        step("R11 sticky",    0, 1, 1, 3'b111, 2'd0, 14'h0,    X_DES,  0, 0, 0, 1, 0);
        do_reinit();

        // Power-down beyond the limit (limit = 3)
        step("R9 pd entry",   0, 0, 1, 3'b111, 2'd0, 14'h0,    X_PDE,  0, 0, 1, 0, 0);
        for (int i = 0; i < 3; i++)
            step("R9 within limit", 0, 0, 1, 3'b111, 2'd0, 14'h0, NONE, 0, 0, 1, 0, 0);
        step("R9 over limit", 0, 0, 1, 3'b111, 2'd0, 14'h0,    NONE,   0, 0, 1, 1, 1);
        step("R9 exit clears starved", 0, 1, 1, 3'b111, 2'd0, 14'h0, X_EXIT, 0, 0, 0, 1, 0);
        do_reinit();

        // Non-exit command while powered down
        step("R6 pd entry",   0, 0, 1, 3'b111, 2'd0, 14'h0,    X_PDE,  0, 0, 1, 0, 0);
        step("R7 act in pd",  0, 1, 0, 3'b011, 2'd0, 14'h0,    NONE,   0, 0, 1, 1, 0);
        do_reinit();

        // Clock-enable drop with a non-idle, non-refresh bus
        step("R11 cke drop act", 0, 0, 0, 3'b011, 2'd0, 14'h0, NONE,   0, 0, 0, 1, 0);
        do_reinit();
        step("R1 after reinit", 0, 1, 0, 3'b111, 2'd0, 14'h0,  X_NOP,  0, 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule